// File: doc/BRIEF.md
# Memory-Cycle Target for a Nibble-Serial Host Bus

This block is the target side of the LPC bus, restricted to single-byte memory read and memory write cycles. The host multiplexes start, cycle type, address and data over a 4-bit bus during each cycle, and frames each cycle with an active-low frame strobe. The block follows the cycle nibble by nibble and collects the address. It takes the bus over after the host's turnaround, reports progress with SYNC codes, and hands the bus back through its own turnaround.

On the storage side, the block raises a byte-wide request with a valid/ready handshake. It then waits for a single response pulse, which carries the byte on reads. While the storage is slow to answer, the block keeps sending wait SYNCs, so storage latency sets the length of the cycle. The block provides the output enable for the shared nibble bus. The bus pads themselves are outside the block.

Top module: `lpc_mem_target`

## Requirements
- R1: After reset the block does not drive the bus (`lad_oe` = 0) and raises no storage request.
- R2: A cycle starts on a clock where `lframe_n` is low and `lad_in` is 0000. When `lframe_n` stays low for several clocks, only the nibble on the last low clock counts. If that nibble is not 0000, the block stays idle and never drives the bus.
- R3: The nibble after the start is the cycle type: 010x selects a memory read and 011x a memory write. Any other value returns the block to idle, and the block does not drive the bus.
- R4: The next eight nibbles form the 32-bit address, most significant nibble first, and this address is presented on `mem_req_addr`.
- R5: On a write, the two nibbles after the address form the data byte, low nibble first. The byte is presented on `mem_req_wdata`, with `mem_req_write` = 1.
- R6: The storage request is raised in the clock where the host drives its first turnaround nibble. Address, direction and data stay stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R7: In the clock after the host's first turnaround clock (1111), the block enables its output and drives 1111.
- R8: The block then drives wait SYNC 0101 until the storage response is sampled, followed by ready SYNC 0000. If storage accepts at once and responds L clocks after acceptance, L-1 waits appear; each clock that ready is withheld adds one wait.
- R9: On a read, the two clocks after the ready SYNC carry the response byte, low nibble first. Both nibbles come from one byte captured when the response arrived.
- R10: After the last data nibble (read) or after the ready SYNC (write), the block drives 1111 for one clock. It then releases the bus and returns to idle.
- R11: `lframe_n` low during a cycle aborts that cycle and decodes the new start. A request that storage has not yet accepted is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Active-low cycle frame from the host |
| lad_in | input | 4 | Nibble bus value as seen at the pads |
| lad_out | output | 4 | Nibble the block drives when enabled |
| lad_oe | output | 1 | Output enable for the nibble bus |
| mem_req_valid | output | 1 | Storage request pending |
| mem_req_ready | input | 1 | Storage accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address of the access |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | One-clock completion pulse from storage |
| mem_rsp_rdata | input | 8 | Read byte, valid with `mem_rsp_valid` |

## Verification
The embedded properties check on every clock that the request fields hold still while storage stalls, and that any rise of the output enable starts with 1111. They also check that read data always follows a ready SYNC, that the captured read byte does not move between its two nibbles, and that the bus is released right after the closing 1111. Only the bench scenarios can show the things that need a full cycle. These are the exact wait-SYNC count for a given storage latency and stall, the nibble ordering of address and data, the rejection of bad start or cycle-type nibbles, and that an aborted cycle leaves no stray storage request.

// File: rtl/lpc_mem_target.sv
module lpc_mem_target #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int NIBS  = ADDR_W / 4;
  localparam int CNT_W = $clog2(NIBS);
  localparam logic [3:0] NB_START = 4'b0000;
  localparam logic [3:0] NB_WAIT  = 4'b0101;
  localparam logic [3:0] NB_READY = 4'b0000;
  localparam logic [3:0] NB_TURN  = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_CYC, S_ADDR, S_WD0, S_WD1, S_HTAR0, S_HTAR1,
    S_SYNC, S_RD0, S_RD1, S_TTAR0, S_TTAR1
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr, pend, busy, live, done;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rbuf;

  assign mem_req_valid = pend && !busy;
  assign mem_req_write = is_wr;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  assign lad_oe = (st == S_HTAR1) || (st == S_SYNC) || (st == S_RD0) ||
                  (st == S_RD1) || (st == S_TTAR0);

  always_comb begin
    case (st)
      S_SYNC:  lad_out = done ? NB_READY : NB_WAIT;
      S_RD0:   lad_out = rbuf[3:0];
      S_RD1:   lad_out = rbuf[7:4];
      default: lad_out = NB_TURN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      is_wr   <= 1'b0;
      pend    <= 1'b0;
      busy    <= 1'b0;
      live    <= 1'b0;
      done    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbuf    <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b0;
        busy <= 1'b1;
        live <= 1'b1;
      end
      if (busy && mem_rsp_valid) begin
        busy <= 1'b0;
        if (live) begin
          done <= 1'b1;
          if (!is_wr) rbuf <= mem_rsp_rdata;
        end
      end
      if (!lframe_n) begin
        st   <= (lad_in == NB_START) ? S_CYC : S_IDLE;
        pend <= 1'b0;
        live <= 1'b0;
        done <= 1'b0;
      end else begin
        case (st)
          S_CYC: begin
            cnt <= '0;
            if (lad_in[3:1] == 3'b010 || lad_in[3:1] == 3'b011) begin
              is_wr <= lad_in[1];
              st    <= S_ADDR;
            end else begin
              st <= S_IDLE;
            end
          end
          S_ADDR: begin
            addr_q <= {addr_q[ADDR_W-5:0], lad_in};
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(NIBS - 1)) begin
              st <= is_wr ? S_WD0 : S_HTAR0;
              if (!is_wr) pend <= 1'b1;
            end
          end
          S_WD0: begin
            wdata_q[3:0] <= lad_in;
            st <= S_WD1;
          end
          S_WD1: begin
            wdata_q[7:4] <= lad_in;
            pend <= 1'b1;
            st <= S_HTAR0;
          end
          S_HTAR0: st <= S_HTAR1;
          S_HTAR1: st <= S_SYNC;
          S_SYNC:  if (done) st <= is_wr ? S_TTAR0 : S_RD0;
          S_RD0:   st <= S_RD1;
          S_RD1:   st <= S_TTAR0;
          S_TTAR0: st <= S_TTAR1;
          S_TTAR1: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && lframe_n |=> mem_req_valid); // R6
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)); // R6
  AST_TAKE_WITH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == NB_TURN); // R7
  AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_RD0) |-> $past(lad_oe) && $past(lad_out) == NB_READY); // R8
  AST_RBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RD0 |=> $stable(rbuf)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TTAR0 |=> !lad_oe); // R10
  AST_BAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CYC && lframe_n && lad_in[3:2] != 2'b01 |=> !lad_oe); // R3

endmodule

// File: tb/lpc_mem_target_tb.sv
`timescale 1ns/1ps
module lpc_mem_target_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe, mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata, mem_rsp_rdata = 8'h00;

  int n_chk = 0, n_bad = 0;
  int cfg_lat = 1, stall_cnt = 0, lat_cnt = 0;
  logic [31:0] acc_addr;
  logic [40:0] q[$];

  always #10 clk = ~clk;

  lpc_mem_target u_dut (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [7:0] rdf(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic [3:0] n);
    @(negedge clk);
    lframe_n = f;
    lad_in   = n;
  endtask

  // storage model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = rdf(acc_addr);
        end
      end
      if (mem_req_valid) begin
        if (stall_cnt > 0) begin
          mem_req_ready = 1'b0;
          stall_cnt--;
        end else begin
          mem_req_ready = 1'b1;
          if (q.size() == 0) begin
            chk(1'b0, "R11 unexpected request", {31'd0, mem_req_write, mem_req_addr}, 64'd0);
          end else begin
            logic [40:0] e;
            e = q.pop_front();
            chk(mem_req_addr == e[39:8], "R4 address", mem_req_addr, e[39:8]);
            chk(mem_req_write == e[40], "R3 direction", mem_req_write, e[40]);
            if (e[40]) chk(mem_req_wdata == e[7:0], "R5 write byte", mem_req_wdata, e[7:0]);
          end
          acc_addr = mem_req_addr;
          lat_cnt  = cfg_lat;
        end
      end
    end
  end

  task automatic host_cycle(input bit wr, input logic [31:0] a, input logic [7:0] wd,
                            input int lat, input int stall, input bit dbl_start);
    int waits;
    logic [7:0] exp_rd;
    cfg_lat   = lat;
    stall_cnt = stall;
    q.push_back({wr, a, wr ? wd : 8'h00});
    exp_rd = rdf(a);
    if (dbl_start) drv(1'b0, 4'hD);
    drv(1'b0, 4'h0);
    drv(1'b1, wr ? 4'b0110 : 4'b0100);
    for (int i = 7; i >= 0; i--) drv(1'b1, a[i*4 +: 4]);
    if (wr) begin
      drv(1'b1, wd[3:0]);
      drv(1'b1, wd[7:4]);
    end
    drv(1'b1, 4'hF);
    @(negedge clk);
    chk(lad_oe && lad_out == 4'hF, "R7 target takes bus with 1111", {lad_oe, lad_out}, 5'h1F);
    waits = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (lad_oe && lad_out == 4'h5) waits++;
      else break;
    end
    chk(lad_oe && lad_out == 4'h0, "R8 ready sync", {lad_oe, lad_out}, 5'h10);
    chk(waits == lat - 1 + stall, "R8 wait sync count", waits, lat - 1 + stall);
    if (!wr) begin
      @(negedge clk);
      chk(lad_oe && lad_out == exp_rd[3:0], "R9 low nibble", lad_out, exp_rd[3:0]);
      @(negedge clk);
      chk(lad_oe && lad_out == exp_rd[7:4], "R9 high nibble", lad_out, exp_rd[7:4]);
    end
    @(negedge clk);
    chk(lad_oe && lad_out == 4'hF, "R10 closing 1111", {lad_oe, lad_out}, 5'h1F);
    @(negedge clk);
    chk(!lad_oe, "R10 bus released", lad_oe, 0);
    chk(q.size() == 0, "R6 request consumed", q.size(), 0);
  endtask

  task automatic no_drive(input string r, input int n);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      drv(1'b1, 4'(i));
      if (lad_oe || mem_req_valid) ok = 1'b0;
    end
    @(negedge clk);
    if (lad_oe || mem_req_valid) ok = 1'b0;
    chk(ok, r, {lad_oe, mem_req_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!lad_oe && !mem_req_valid, "R1 reset state", {lad_oe, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!lad_oe && !mem_req_valid, "R1 after reset", {lad_oe, mem_req_valid}, 0);

    host_cycle(1'b0, 32'h1234_5678, 8'h00, 1, 0, 1'b0);
    host_cycle(1'b1, 32'hFEDC_BA98, 8'h3C, 1, 0, 1'b0);
    host_cycle(1'b0, 32'h0000_00F1, 8'h00, 4, 0, 1'b0);
    host_cycle(1'b1, 32'h8000_0001, 8'hA7, 3, 2, 1'b0);
    host_cycle(1'b0, 32'hCAFE_0042, 8'h00, 2, 3, 1'b1);

    // R2: a non-zero start nibble leaves the block idle
    drv(1'b0, 4'hD);
    no_drive("R2 bad start ignored", 14);
    // R2: last low-frame nibble wins (0000 then 1101)
    drv(1'b0, 4'h0);
    drv(1'b0, 4'hD);
    no_drive("R2 last start nibble wins", 14);
    // R3: I/O-type cycle nibble is rejected
    drv(1'b0, 4'h0);
    drv(1'b1, 4'b0010);
    no_drive("R3 bad cycle type ignored", 14);

    // R11: abort mid-address then a full write
    drv(1'b0, 4'h0);
    drv(1'b1, 4'b0100);
    drv(1'b1, 4'h9);
    drv(1'b1, 4'h9);
    drv(1'b1, 4'h9);
    host_cycle(1'b1, 32'h0BAD_F00D, 8'h5E, 2, 0, 1'b0);
    chk(q.size() == 0, "R11 no stray request after abort", q.size(), 0);

    drv(1'b1, 4'hF);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule